// File: doc/BRIEF.md
# General-Purpose I/O Controller with Set/Clear Latch and Edge Capture

This block controls a bank of general-purpose pins (28 by default) from a simple register bus. Software chooses, pin by pin, whether the pad is driven (output enable) and whether the pin is handed to an alternate on-chip peripheral. The output latch can never be written directly. One register address sets latch bits where ones are written, and another clears them, so separate software agents can change their own pins without a read-modify-write race.

Incoming pin levels pass through a two-stage synchronizer. The synchronized value is readable as the level register and also feeds a per-pin edge detector. Rising and falling edges each have their own enable mask. A detected edge sets a sticky bit in a status register, which software clears by writing ones. The interrupt output is high while any status bit is set.

Register indices on `bus_addr`: 0 level (read only), 1 direction, 2 set (reads back the latch), 3 clear (reads back the latch), 4 rising-edge enable, 5 falling-edge enable, 6 edge status, 7 alternate-function select. Reads are combinational from `bus_addr`. A write takes effect at the rising clock edge where `bus_wr` is high.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, `pin_oe`, `pin_out`, the direction, both edge enables, the alternate-function select, the edge status and `irq` are all zero.
- R2: Reading index 0 returns the pin levels (1 = high). A change on `pin_in` before rising edge k is still hidden after edge k and appears after edge k+1. Writes to index 0 change nothing.
- R3: `pin_oe` equals the direction register (index 1), where a 1 makes that pin an output.
- R4: Writing index 2 sets every latch bit written as 1 and leaves bits written as 0 unchanged.
- R5: Writing index 3 clears every latch bit written as 1 and leaves bits written as 0 unchanged.
- R6: With its rising enable bit (index 4) set, a 0-to-1 pin change before edge k sets that status bit after edge k+2. A pin whose enable is clear never sets its status bit.
- R7: With its falling enable bit (index 5) set, a 1-to-0 pin change sets that status bit with the same timing as R6. A falling change on a pin that only has its rising enable set leaves status unchanged.
- R8: Writing index 6 clears each status bit written as 1 and keeps bits written as 0.
- R9: If an edge event and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R10: Where the alternate-function bit (index 7) is 1, `pin_out` follows `alt_out` and `alt_in` shows the synchronized pin level. Where it is 0, `pin_out` follows the latch and `alt_in` reads 0.
- R11: `irq` is high exactly while at least one edge status bit is set.
- R12: Reading index 2 or index 3 returns the current output latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | N | Pad input levels, asynchronous |
| pin_out | output | N | Pad output values |
| pin_oe | output | N | Pad output enables |
| alt_out | input | N | Output values from alternate peripherals |
| alt_in | output | N | Synchronized levels to alternate peripherals |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | N | Write data |
| bus_rdata | output | N | Read data for `bus_addr` |
| irq | output | 1 | Edge interrupt, OR of status bits |

## Verification
The assertions assume that only the bus writes the latch and the status register, and that only the synchronized pin history creates edge events. They also assume one register is written per cycle, so set and clear never reach the latch together. The stimulus changes pins and bus signals only at falling clock edges and strobes each write for a single cycle. After each pin change it waits at least three cycles, so every transition produces exactly one event. The coincidence case of R9 is built by timing a clear strobe to land on the edge at which the detector fires.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int REG_IDX_W = 3;

  typedef enum logic [REG_IDX_W-1:0] {
    RG_LEVEL = 3'd0,
    RG_DIR   = 3'd1,
    RG_SET   = 3'd2,
    RG_CLR   = 3'd3,
    RG_RISE  = 3'd4,
    RG_FALL  = 3'd5,
    RG_STAT  = 3'd6,
    RG_ALT   = 3'd7
  } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 28,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] lvl,
  output logic [W-1:0] lvl_prev
);
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] q;
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) q <= '0;
          else        q <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) q <= '0;
          else        q <= g_stage[s-1].q;
      end
    end
  endgenerate

  assign lvl = g_stage[STAGES-1].q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lvl_prev <= '0;
    else        lvl_prev <= lvl;
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] lvl_prev,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] w1c_mask,
  output logic [W-1:0] rise_evt,
  output logic [W-1:0] fall_evt,
  output logic [W-1:0] evt_any,
  output logic [W-1:0] status
);
  function automatic logic [W-1:0] went_high(input logic [W-1:0] cur,
                                              input logic [W-1:0] old,
                                              input logic [W-1:0] en);
    return cur & ~old & en;
  endfunction

  function automatic logic [W-1:0] sticky_next(input logic [W-1:0] st,
                                                input logic [W-1:0] ev,
                                                input logic [W-1:0] clr);
    // an event in the clearing cycle wins over the clear
    return (st & ~clr) | ev;
  endfunction

  assign rise_evt = went_high(lvl, lvl_prev, rise_en);
  assign fall_evt = went_high(~lvl, ~lvl_prev, fall_en);
  assign evt_any  = rise_evt | fall_evt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) status <= '0;
    else        status <= sticky_next(status, evt_any, w1c_mask);
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int W = 28
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [REG_IDX_W-1:0] addr,
  input  logic [W-1:0]         wdata,
  input  logic [W-1:0]         level,
  input  logic [W-1:0]         status,
  output logic [W-1:0]         dir_q,
  output logic [W-1:0]         rise_en_q,
  output logic [W-1:0]         fall_en_q,
  output logic [W-1:0]         alt_q,
  output logic [W-1:0]         latch_q,
  output logic [W-1:0]         set_mask,
  output logic [W-1:0]         clr_mask,
  output logic [W-1:0]         w1c_mask,
  output logic [W-1:0]         rdata
);
  gpio_reg_e sel;
  assign sel = gpio_reg_e'(addr);

  function automatic logic [W-1:0] hit(input logic en, input logic [W-1:0] v);
    return en ? v : '0;
  endfunction

  function automatic logic [W-1:0] setclr(input logic [W-1:0] cur,
                                           input logic [W-1:0] s,
                                           input logic [W-1:0] c);
    // clear has priority when both name the same bit
    return (cur | s) & ~c;
  endfunction

  assign set_mask = hit(wr && sel == RG_SET,  wdata);
  assign clr_mask = hit(wr && sel == RG_CLR,  wdata);
  assign w1c_mask = hit(wr && sel == RG_STAT, wdata);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir_q     <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
      alt_q     <= '0;
      latch_q   <= '0;
    end else begin
      latch_q <= setclr(latch_q, set_mask, clr_mask);
      if (wr) begin
        case (sel)
          RG_DIR:  dir_q     <= wdata;
          RG_RISE: rise_en_q <= wdata;
          RG_FALL: fall_en_q <= wdata;
          RG_ALT:  alt_q     <= wdata;
          default: ;
        endcase
      end
    end

  always_comb begin
    case (sel)
      RG_LEVEL: rdata = level;
      RG_DIR:   rdata = dir_q;
      RG_SET,
      RG_CLR:   rdata = latch_q;
      RG_RISE:  rdata = rise_en_q;
      RG_FALL:  rdata = fall_en_q;
      RG_STAT:  rdata = status;
      RG_ALT:   rdata = alt_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int N           = 28,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         pin_in,
  output logic [N-1:0]         pin_out,
  output logic [N-1:0]         pin_oe,
  input  logic [N-1:0]         alt_out,
  output logic [N-1:0]         alt_in,
  input  logic                 bus_wr,
  input  logic [REG_IDX_W-1:0] bus_addr,
  input  logic [N-1:0]         bus_wdata,
  output logic [N-1:0]         bus_rdata,
  output logic                 irq
);
  logic [N-1:0] level, level_prev;
  logic [N-1:0] dir_q, rise_en_q, fall_en_q, alt_q, latch_q;
  logic [N-1:0] set_mask, clr_mask, w1c_mask;
  logic [N-1:0] rise_evt, fall_evt, evt_any, status_q;

  function automatic logic [N-1:0] pick(input logic [N-1:0] sel,
                                         input logic [N-1:0] a,
                                         input logic [N-1:0] b);
    return (a & sel) | (b & ~sel);
  endfunction

  gpio_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .lvl(level), .lvl_prev(level_prev)
  );

  gpio_regs #(.W(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .level(level), .status(status_q),
    .dir_q(dir_q), .rise_en_q(rise_en_q), .fall_en_q(fall_en_q), .alt_q(alt_q),
    .latch_q(latch_q), .set_mask(set_mask), .clr_mask(clr_mask),
    .w1c_mask(w1c_mask), .rdata(bus_rdata)
  );

  gpio_edge #(.W(N)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(level), .lvl_prev(level_prev),
    .rise_en(rise_en_q), .fall_en(fall_en_q), .w1c_mask(w1c_mask),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .evt_any(evt_any),
    .status(status_q)
  );

  assign pin_oe  = dir_q;
  assign pin_out = pick(alt_q, alt_out, latch_q);
  assign alt_in  = pick(alt_q, level, '0);
  assign irq     = |status_q;
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
  parameter int N = 28
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] status_q,
  input logic [N-1:0] evt_any,
  input logic [N-1:0] w1c_mask,
  input logic [N-1:0] set_mask,
  input logic [N-1:0] clr_mask,
  input logic [N-1:0] latch_q,
  input logic         irq
);
  // R6
  status_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~$past(status_q) & ~$past(evt_any)) == '0);

  // R8
  status_drop_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status_q) & ~status_q & ~$past(w1c_mask)) == '0);

  // R9
  event_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(w1c_mask & evt_any) & ~status_q) == '0);

  // R4
  latch_rise_needs_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q & ~$past(latch_q) & ~$past(set_mask)) == '0);

  // R5
  latch_fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(latch_q) & ~latch_q & ~$past(clr_mask)) == '0);

  // R11
  irq_rise_after_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(evt_any) != '0));
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .status_q(status_q), .evt_any(evt_any),
  .w1c_mask(w1c_mask), .set_mask(set_mask), .clr_mask(clr_mask),
  .latch_q(latch_q), .irq(irq)
);

// File: tb/gpio_ctrl_test.sv
module gpio_ctrl_test;
  localparam int N = 28;
  localparam int K_RD = 0, K_OUT = 1, K_OE = 2, K_IRQ = 3, K_ALT = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pin_in = '0;
  logic [N-1:0] pin_out, pin_oe, alt_in, bus_rdata;
  logic [N-1:0] alt_out = '0;
  logic         bus_wr = 1'b0;
  logic [2:0]   bus_addr = 3'd0;
  logic [N-1:0] bus_wdata = '0;
  logic         irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    int           kind;
    logic [N-1:0] exp;
    string        tag;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  gpio_ctrl #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .alt_out(alt_out), .alt_in(alt_in), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      item_t it;
      logic [N-1:0] act;
      wait (q.size() != 0);
      #1;
      it = q.pop_front();
      case (it.kind)
        K_RD:    act = bus_rdata;
        K_OUT:   act = pin_out;
        K_OE:    act = pin_oe;
        K_IRQ:   act = N'(irq);
        default: act = alt_in;
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_val(int kind, logic [2:0] a, logic [N-1:0] e, string tag);
    item_t it;
    bus_addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
    #2;
  endtask

  task automatic wr(logic [2:0] a, logic [N-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic pins(logic [N-1:0] v, int waits);
    @(negedge clk);
    pin_in = v;
    for (int i = 0; i < waits; i++) @(negedge clk);
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [N-1:0] p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    expect_val(K_OE, 0, '0, "R1 pin_oe");
    expect_val(K_OUT, 0, '0, "R1 pin_out");
    expect_val(K_IRQ, 0, '0, "R1 irq");
    expect_val(K_RD, 3'd6, '0, "R1 status");
    expect_val(K_RD, 3'd1, '0, "R1 dir");
    expect_val(K_RD, 3'd7, '0, "R1 alt");
    expect_val(K_RD, 3'd4, '0, "R1 rise_en");
    expect_val(K_RD, 3'd5, '0, "R1 fall_en");

    // R2 synchronizer latency and level readback
    p = 28'h0A55A5C;
    pins(p, 1);
    expect_val(K_RD, 3'd0, '0, "R2 level still hidden");
    @(negedge clk);
    expect_val(K_RD, 3'd0, p, "R2 level visible");
    wr(3'd0, '1);
    expect_val(K_RD, 3'd0, p, "R2 level write ignored");

    // R3 direction
    wr(3'd1, 28'h00FF00F);
    expect_val(K_OE, 0, 28'h00FF00F, "R3 pin_oe");

    // R4 / R12 set
    wr(3'd2, 28'h00000F0);
    expect_val(K_OUT, 0, 28'h00000F0, "R4 set");
    wr(3'd2, 28'h0000003);
    expect_val(K_OUT, 0, 28'h00000F3, "R4 zeros keep");
    expect_val(K_RD, 3'd2, 28'h00000F3, "R12 read via set index");

    // R5 clear
    wr(3'd3, 28'h0000030);
    expect_val(K_OUT, 0, 28'h00000C3, "R5 clear");
    expect_val(K_RD, 3'd3, 28'h00000C3, "R12 read via clear index");

    // R10 alternate function
    alt_out = '0;
    wr(3'd7, 28'h0000005);
    expect_val(K_OUT, 0, 28'h00000C2, "R10 pin_out from alt_out");
    expect_val(K_ALT, 0, 28'h0000004, "R10 alt_in masked level");
    wr(3'd7, '0);
    expect_val(K_OUT, 0, 28'h00000C3, "R10 back to latch");
    expect_val(K_ALT, 0, '0, "R10 alt_in zero");

    // R6 rising detect: bit8 rises (enabled), bit4 falls, bit12 toggles (not enabled)
    wr(3'd4, 28'h0000110);
    p = p ^ 28'h0001110;
    pins(p, 2);
    expect_val(K_RD, 3'd6, '0, "R6 not yet captured");
    @(negedge clk);
    expect_val(K_RD, 3'd6, 28'h0000100, "R6 rising captured");
    expect_val(K_IRQ, 0, 28'h1, "R11 irq high");

    // R7 falling detect on bit4
    wr(3'd5, 28'h0000010);
    p = p ^ 28'h0000010;
    pins(p, 3);
    expect_val(K_RD, 3'd6, 28'h0000110, "R6 bit4 rise enabled");
    wr(3'd4, 28'h0000100);
    p = p ^ 28'h0000010;
    pins(p, 3);
    expect_val(K_RD, 3'd6, 28'h0000110, "R7 falling keeps set");
    wr(3'd6, 28'h0000110);
    p = p ^ 28'h0000010;
    pins(p, 3);
    expect_val(K_RD, 3'd6, '0, "R7 rise not enabled on bit4");
    p = p ^ 28'h0000010;
    pins(p, 3);
    expect_val(K_RD, 3'd6, 28'h0000010, "R7 falling captured");

    // R8 write-one-to-clear
    p = p ^ 28'h0000100;
    pins(p, 3);
    expect_val(K_RD, 3'd6, 28'h0000010, "R8 bit8 fall not enabled");
    p = p ^ 28'h0000100;
    pins(p, 3);
    expect_val(K_RD, 3'd6, 28'h0000110, "R8 setup");
    wr(3'd6, 28'h0000010);
    expect_val(K_RD, 3'd6, 28'h0000100, "R8 partial clear");
    expect_val(K_IRQ, 0, 28'h1, "R11 irq still high");
    wr(3'd6, 28'h0000100);
    expect_val(K_RD, 3'd6, '0, "R8 full clear");
    expect_val(K_IRQ, 0, '0, "R11 irq low");

    // R9 event coinciding with clear
    wr(3'd5, 28'h0000100);
    p = p ^ 28'h0000100;
    pins(p, 3);
    expect_val(K_RD, 3'd6, 28'h0000100, "R9 setup");
    @(negedge clk);
    p = p ^ 28'h0000100;
    pin_in = p;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'd6; bus_wdata = 28'h0000100;
    @(negedge clk);
    bus_wr = 1'b0;
    expect_val(K_RD, 3'd6, 28'h0000100, "R9 event wins over clear");
    expect_val(K_IRQ, 0, 28'h1, "R9 irq stays");
    wr(3'd6, 28'h0000100);
    expect_val(K_RD, 3'd6, '0, "R9 later clear works");

    done = 1'b1;
    report();
  end
endmodule